// File: doc/BRIEF.md
# ADC control register interface

This block is the register side of a successive-approximation ADC peripheral. The analog converter is not part of it. A small memory-mapped byte bus reaches five registers:
- a channel/alignment register,
- a second control register,
- a control/status register with a start bit, a busy bit and a completion flag,
- the low and high bytes of the 16-bit result.

The block drives an external converter with a one-cycle start pulse and a channel code. It captures the 10-bit sample when the converter signals that it is done.

The block keeps two copies of the 6-bit channel code. The live copy is what software last wrote. The active copy is what the converter uses. The active copy follows the live one while the converter is idle. During a conversion it is frozen, and it is refreshed in the cycle that the conversion ends. The raw sample is stored unaligned, and alignment is applied on the read path. Flipping the alignment bit therefore changes what the result bytes read at once, even while a conversion is running.

Top module: `adc_regif`

## Requirements
- R1: After reset, every register reads 0x00, `conv_start` is 0, `conv_chan` is 0, `trig_sel` is 0 and `ctrl_aux` is 0.
- R2: The register at address 0 holds the alignment bit in bit 5 and the low five channel bits in bits 4:0. Bits 7:6 read 0. While idle, `conv_chan` follows the written channel after one further cycle.
- R3: The register at address 1 holds a read/write spare bit in bit 6 (driven on `ctrl_aux`), the channel high bit in bit 3, and the trigger-source field in bits 2:0 (driven on `trig_sel`). Bits 7, 5 and 4 always read 0.
- R4: Writing a value with bit 0 set to address 2 while idle raises `conv_start` for exactly one cycle, starting in the cycle after the write, and sets the busy bit (address 2 bit 2). The same write while busy is ignored.
- R5: During a conversion, `conv_chan` keeps the channel code in force at its start, even if either channel field is written.
- R6: When a conversion completes, the active channel is reloaded from the live channel fields. The next conversion uses the channel written mid-conversion.
- R7: A `conv_done` pulse while busy captures `conv_sample`, sets the completion flag (address 2 bit 1) and clears busy.
- R8: With the alignment bit 0, the result reads right-adjusted: sample in bits 9:0 and bits 15:10 zero. The low byte is at address 3 and the high byte at address 4.
- R9: With the alignment bit 1, the result reads left-adjusted: sample in bits 15:6 and bits 5:0 zero.
- R10: A change of the alignment bit changes the result read in the very next read, including in the middle of a conversion.
- R11: The completion flag is cleared only by writing 1 to address 2 bit 1. Writing 0 there has no effect. A completion in the same cycle as a clear leaves the flag set.
- R12: A `conv_done` pulse while idle is ignored: the flag stays clear and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 6 | Active channel code for the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_sample | input | 10 | Converter sample, valid with `conv_done` |
| trig_sel | output | 3 | Trigger-source field |
| ctrl_aux | output | 1 | Spare control bit |

## Verification
The bench uses the default parameters: a 3-bit address, an 8-bit bus, a 10-bit sample and a 5-bit low channel field. This gives six padding bits in the 16-bit result, so left and right alignment differ by a visible 6-bit shift in both bytes. The full 6-bit channel code, including the high bit that lives in the second control register, can be observed on `conv_chan`. With these widths the bench can write both channel fields in the middle of a conversion and confirm that the code is held until completion. It can also flip alignment while busy, and make a completion and a flag clear land in the same cycle.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  // register offsets (bus address)
  localparam int REG_MUX    = 0;
  localparam int REG_CTLB   = 1;
  localparam int REG_CTLA   = 2;
  localparam int REG_RES_LO = 3;
  localparam int REG_RES_HI = 4;
  localparam int NUM_REGS   = 5;

  // second control register layout
  localparam int CTLB_AUX_BIT  = 6;
  localparam int CTLB_CHHI_BIT = 3;
  localparam int TRIG_W        = 3;

  // control/status register layout
  localparam int STAT_GO_BIT   = 0;
  localparam int STAT_FLAG_BIT = 1;
  localparam int STAT_BUSY_BIT = 2;
endpackage

// File: rtl/adc_reg_decode.sv
module adc_reg_decode #(
  parameter int ADDR_W = 3,
  parameter int NREG   = 5
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic [NREG-1:0]   wr_sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = bus_wr && (bus_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int CH_W  = 6,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  live_ch,
  input  logic             start_req,
  input  logic             flag_clr,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_sample,
  output logic             conv_start,
  output logic [CH_W-1:0]  active_ch,
  output logic             busy,
  output logic             flag,
  output logic [RES_W-1:0] raw,
  output logic             evt_start,
  output logic             evt_capture
);
  logic             busy_q, start_q, flag_q;
  logic [CH_W-1:0]  active_q;
  logic [RES_W-1:0] raw_q;

  assign evt_start   = start_req && !busy_q;
  assign evt_capture = conv_done && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      flag_q   <= 1'b0;
      active_q <= '0;
      raw_q    <= '0;
    end else begin
      start_q <= evt_start;
      if (evt_start)        busy_q <= 1'b1;
      else if (evt_capture) busy_q <= 1'b0;
      if (evt_capture)      flag_q <= 1'b1;
      else if (flag_clr)    flag_q <= 1'b0;
      if (evt_capture)      raw_q  <= conv_sample;
      if (!busy_q || evt_capture) active_q <= live_ch;
    end
  end

  assign conv_start = start_q;
  assign active_ch  = active_q;
  assign busy       = busy_q;
  assign flag       = flag_q;
  assign raw        = raw_q;
endmodule

// File: rtl/adc_result_align.sv
module adc_result_align #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic [RES_W-1:0] raw,
  input  logic             left,
  output logic [OUT_W-1:0] aligned
);
  localparam int PAD_W = OUT_W - RES_W;

  function automatic logic [OUT_W-1:0] place(input logic [RES_W-1:0] v, input logic l);
    if (l) return {v, {PAD_W{1'b0}}};
    else   return {{PAD_W{1'b0}}, v};
  endfunction

  assign aligned = place(raw, left);
endmodule

// File: rtl/adc_regif.sv
module adc_regif #(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 8,
  parameter int RES_W  = 10,
  parameter int CHLO_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic [BUS_W-1:0]             bus_wdata,
  output logic [BUS_W-1:0]             bus_rdata,
  output logic                         conv_start,
  output logic [CHLO_W:0]              conv_chan,
  input  logic                         conv_done,
  input  logic [RES_W-1:0]             conv_sample,
  output logic [adc_regif_pkg::TRIG_W-1:0] trig_sel,
  output logic                         ctrl_aux
);
  import adc_regif_pkg::*;

  localparam int CH_W  = CHLO_W + 1;
  localparam int OUT_W = 2 * BUS_W;
  localparam int MUX_PAD = BUS_W - CHLO_W - 1;

  logic [NUM_REGS-1:0] wr_sel;
  logic                align_q, ch_hi_q, aux_q;
  logic [CHLO_W-1:0]   ch_lo_q;
  logic [TRIG_W-1:0]   trig_q;
  logic [CH_W-1:0]     live_ch, active_ch;
  logic                start_req, flag_clr;
  logic                conv_busy, done_flag, evt_start, evt_capture;
  logic [RES_W-1:0]    raw;
  logic [OUT_W-1:0]    aligned;
  logic                unused_wbits;

  adc_reg_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .wr_sel(wr_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_q <= 1'b0;
      ch_lo_q <= '0;
      ch_hi_q <= 1'b0;
      aux_q   <= 1'b0;
      trig_q  <= '0;
    end else begin
      if (wr_sel[REG_MUX]) begin
        align_q <= bus_wdata[CHLO_W];
        ch_lo_q <= bus_wdata[CHLO_W-1:0];
      end
      if (wr_sel[REG_CTLB]) begin
        aux_q   <= bus_wdata[CTLB_AUX_BIT];
        ch_hi_q <= bus_wdata[CTLB_CHHI_BIT];
        trig_q  <= bus_wdata[TRIG_W-1:0];
      end
    end
  end

  assign live_ch   = {ch_hi_q, ch_lo_q};
  assign start_req = wr_sel[REG_CTLA] && bus_wdata[STAT_GO_BIT];
  assign flag_clr  = wr_sel[REG_CTLA] && bus_wdata[STAT_FLAG_BIT];
  assign unused_wbits = ^bus_wdata;

  adc_conv_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .live_ch(live_ch), .start_req(start_req),
    .flag_clr(flag_clr), .conv_done(conv_done), .conv_sample(conv_sample),
    .conv_start(conv_start), .active_ch(active_ch), .busy(conv_busy),
    .flag(done_flag), .raw(raw), .evt_start(evt_start), .evt_capture(evt_capture)
  );

  adc_result_align #(.RES_W(RES_W), .OUT_W(OUT_W)) u_align (
    .raw(raw), .left(align_q), .aligned(aligned)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_MUX):    bus_rdata = {{MUX_PAD{1'b0}}, align_q, ch_lo_q};
      ADDR_W'(REG_CTLB): begin
        bus_rdata[CTLB_AUX_BIT]  = aux_q;
        bus_rdata[CTLB_CHHI_BIT] = ch_hi_q;
        bus_rdata[TRIG_W-1:0]    = trig_q;
      end
      ADDR_W'(REG_CTLA): begin
        bus_rdata[STAT_BUSY_BIT] = conv_busy;
        bus_rdata[STAT_FLAG_BIT] = done_flag;
      end
      ADDR_W'(REG_RES_LO): bus_rdata = aligned[BUS_W-1:0];
      ADDR_W'(REG_RES_HI): bus_rdata = aligned[OUT_W-1:BUS_W];
      default:             bus_rdata = '0;
    endcase
  end

  assign conv_chan = active_ch;
  assign trig_sel  = trig_q;
  assign ctrl_aux  = aux_q;
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int ADDR_W = 3,
  parameter int BUS_W  = 8,
  parameter int CH_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              conv_start,
  input logic              conv_done,
  input logic [CH_W-1:0]   conv_chan,
  input logic              busy,
  input logic              flag,
  input logic              evt_capture
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R4
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> $stable(conv_chan)); // R5
  AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> (flag && !busy)); // R7
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && conv_done && !flag) |=> !flag); // R12
  AST_CTLB_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(1)) |-> (bus_rdata[7] == 1'b0 && bus_rdata[5:4] == 2'b00)); // R3
endmodule

bind adc_regif adc_regif_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CHLO_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .conv_start(conv_start), .conv_done(conv_done), .conv_chan(conv_chan),
  .busy(conv_busy), .flag(done_flag), .evt_capture(evt_capture)
);

// File: tb/adc_regif_test.sv
module adc_regif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       conv_start;
  logic [5:0] conv_chan;
  logic       conv_done = 1'b0;
  logic [9:0] conv_sample = '0;
  logic [2:0] trig_sel;
  logic       ctrl_aux;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  adc_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_sample(conv_sample),
    .trig_sel(trig_sel), .ctrl_aux(ctrl_aux)
  );

  function automatic logic [15:0] expect_result(input int sample, input bit left);
    int v;
    v = left ? sample * 64 : sample;
    return v[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_conv(input logic [9:0] s);
    @(negedge clk);
    conv_done = 1'b1; conv_sample = s;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg%0d", a), {8'h0, d}, 16'h0);
    end
    check("R1 conv_start", {15'h0, conv_start}, 16'h0);
    check("R1 conv_chan", {10'h0, conv_chan}, 16'h0);
    check("R1 trig_sel/aux", {12'h0, ctrl_aux, trig_sel}, 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    check("R2 mux readback", {8'h0, d}, 16'h003F);
    wr(3'd1, 8'hFF);
    rd(3'd1, d);
    check("R3 ctlb readback", {8'h0, d}, 16'h004F);
    check("R3 trig_sel/aux", {12'h0, ctrl_aux, trig_sel}, 16'h000F);
    check("R2 idle channel follow", {10'h0, conv_chan}, 16'h003F);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_convert();
    logic [7:0] d;
    wr(3'd0, 8'h05);
    wr(3'd2, 8'h01);
    check("R4 start pulse", {15'h0, conv_start}, 16'h1);
    check("R5 chan at start", {10'h0, conv_chan}, 16'h5);
    @(negedge clk);
    check("R4 start one cycle", {15'h0, conv_start}, 16'h0);
    rd(3'd2, d);
    check("R4 busy bit", {8'h0, d}, 16'h0004);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h08);
    check("R5 chan held", {10'h0, conv_chan}, 16'h5);
    wr(3'd2, 8'h01);
    check("R4 start ignored while busy", {15'h0, conv_start}, 16'h0);
    finish_conv(10'h2A5);
    rd(3'd2, d);
    check("R7 flag set busy clear", {8'h0, d}, 16'h0002);
    check("R6 chan reloaded", {10'h0, conv_chan}, 16'h0022);
    rd(3'd3, d);
    check("R8 right low", {8'h0, d}, {8'h0, expect_result(10'h2A5, 0)[7:0]});
    rd(3'd4, d);
    check("R8 right high", {8'h0, d}, {8'h0, expect_result(10'h2A5, 0)[15:8]});
  endtask

  task automatic t_align();
    logic [7:0] d;
    wr(3'd2, 8'h03);
    check("R6 next conv new chan", {10'h0, conv_chan}, 16'h0022);
    wr(3'd0, 8'h22);
    rd(3'd4, d);
    check("R10 left high mid-conv", {8'h0, d}, {8'h0, expect_result(10'h2A5, 1)[15:8]});
    rd(3'd3, d);
    check("R9 left low mid-conv", {8'h0, d}, {8'h0, expect_result(10'h2A5, 1)[7:0]});
    wr(3'd0, 8'h02);
    rd(3'd4, d);
    check("R10 back to right", {8'h0, d}, {8'h0, expect_result(10'h2A5, 0)[15:8]});
    wr(3'd0, 8'h22);
    finish_conv(10'h3FF);
    rd(3'd3, d);
    check("R9 left low full", {8'h0, d}, {8'h0, expect_result(10'h3FF, 1)[7:0]});
    rd(3'd4, d);
    check("R9 left high full", {8'h0, d}, {8'h0, expect_result(10'h3FF, 1)[15:8]});
  endtask

  task automatic t_flag();
    logic [7:0] d;
    wr(3'd2, 8'h00);
    rd(3'd2, d);
    check("R11 write 0 keeps flag", {8'h0, d}, 16'h0002);
    wr(3'd2, 8'h02);
    rd(3'd2, d);
    check("R11 write 1 clears flag", {8'h0, d}, 16'h0000);
    finish_conv(10'h155);
    rd(3'd2, d);
    check("R12 idle done no flag", {8'h0, d}, 16'h0000);
    rd(3'd4, d);
    check("R12 idle done result kept", {8'h0, d}, {8'h0, expect_result(10'h3FF, 1)[15:8]});
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h01);
    @(negedge clk);
    bus_addr = 3'd2; bus_wdata = 8'h02; bus_wr = 1'b1;
    conv_done = 1'b1; conv_sample = 10'h011;
    @(negedge clk);
    bus_wr = 1'b0; conv_done = 1'b0;
    rd(3'd2, d);
    check("R11 set wins over clear", {8'h0, d}, 16'h0002);
    rd(3'd3, d);
    check("R7 sample captured", {8'h0, d}, {8'h0, expect_result(10'h011, 0)[7:0]});
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_convert();
    t_align();
    t_flag();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end
endmodule